// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block caches address translations for a 32-bit virtual space with 4 KB pages. It has 16 sets of 4 ways. A lookup presents a 20-bit virtual page number, the 12-bit page offset and the kind of entry wanted. One cycle later the block returns hit or miss. On a hit it also returns the cached physical page number, the physical address, the user and write permission bits, the global bit and the entry kind. An entry caches either a directory-level mapping or a final page-level mapping, and a kind flag tells the two apart.

A table walker outside this block writes entries through the fill port. A fill first reuses a way that already holds the same tag and kind. Failing that, it takes the lowest invalid way. With all four ways valid, it replaces the way named by a round-robin pointer kept per set. Two flushes exist. The full flush drops everything. The task-switch flush keeps only the entries marked global.

Top module: `tlb_sa`

## Requirements
- R1: `rsp_valid_o` is high in exactly the cycle after a cycle in which `lu_valid_i` was high, and low otherwise.
- R2: The set index is `vpn[3:0]` and the tag is `vpn[19:4]`. A hit needs a valid entry in the indexed set with an equal tag and an equal kind flag. A different index misses.
- R3: After reset no entry is valid, so every lookup misses.
- R4: On a hit the block returns the stored page number on `rsp_ppn_o`, `{ppn, offset}` on `rsp_pa_o`, and the stored user, write and global bits. On a miss these outputs are zero.
- R5: The kind flag is 1 for a directory-level entry and 0 for a page-level entry. Entries of the two kinds with the same page number coexist, and each is found only by a lookup of its own kind.
- R6: A fill whose tag and kind already sit in a valid way of the set overwrites that way. It does not advance the round-robin pointer.
- R7: A fill that matches no way writes the lowest-numbered invalid way of the set, so four distinct fills into an empty set all stay resident.
- R8: A fill into a full set with no match replaces the way named by that set's 2-bit pointer, then increments the pointer. The pointer is 0 after reset, and flushes leave it unchanged.
- R9: A task-switch flush keeps the valid entries that have the global bit set and invalidates all others in one cycle.
- R10: A full flush invalidates every entry in one cycle, global or not.
- R11: A fill presented in the same cycle as either flush is dropped.
- R12: A lookup and a fill presented in the same cycle return a response that already reflects the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lu_valid_i | input | 1 | Lookup strobe |
| lu_vpn_i | input | 20 | Lookup virtual page number |
| lu_off_i | input | 12 | Lookup page offset |
| lu_dir_i | input | 1 | Kind sought: 1 directory, 0 page |
| fill_i | input | 1 | Write one entry |
| fill_vpn_i | input | 20 | Fill virtual page number |
| fill_ppn_i | input | 20 | Fill physical page number |
| fill_dir_i | input | 1 | Fill kind flag |
| fill_user_i | input | 1 | Fill user-access bit |
| fill_write_i | input | 1 | Fill write-allowed bit |
| fill_global_i | input | 1 | Fill global bit |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_task_i | input | 1 | Invalidate non-global entries |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_dir_o | output | 1 | Kind of the hit entry |
| rsp_ppn_o | output | 20 | Physical page number of the hit |
| rsp_pa_o | output | 32 | Physical address of the hit |
| rsp_user_o | output | 1 | User-access bit of the hit |
| rsp_write_o | output | 1 | Write-allowed bit of the hit |
| rsp_global_o | output | 1 | Global bit of the hit |

## Verification
A corrupted valid or global bit shows up on the next lookup of that set. The lookup returns a stale hit or a lost entry one cycle after the strobe, and the flush tests expose it directly. A wrong replacement pointer or a wrong choice of invalid way leaves the ports silent until a later lookup. That lookup finds a surviving tag missing or an evicted tag still present. So the bench fills sets past capacity, in a known order, and then probes each tag. A fill that lands in the wrong way, or that creates a duplicate, changes which tag the next eviction removes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VPN_W = 20;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned PPN_W = 20;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 16
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0]            dir_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]           tag_q_i,
  input  logic                       dir_q_i,
  output logic [WAYS-1:0]            hit_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_o[w] = valid_i[w] && (dir_i[w] == dir_q_i) && (tag_i[w] == tag_q_i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WW  = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] valid_i,
  input  logic [WAYS-1:0] match_i,
  input  logic [WW-1:0]   ptr_i,
  output logic [WW-1:0]   way_o,
  output logic            rr_o
);
  always_comb begin
    way_o = ptr_i;
    rr_o  = 1'b1;
    // descending scan: lowest index wins
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        way_o = WW'(i);
        rr_o  = 1'b0;
      end
    end
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        way_o = WW'(i);
        rr_o  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlb_sa.sv
module tlb_sa #(
  parameter int unsigned SETS = 16,
  parameter int unsigned WAYS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       lu_valid_i,
  input  logic [tlb_pkg::VPN_W-1:0]  lu_vpn_i,
  input  logic [tlb_pkg::OFF_W-1:0]  lu_off_i,
  input  logic                       lu_dir_i,
  input  logic                       fill_i,
  input  logic [tlb_pkg::VPN_W-1:0]  fill_vpn_i,
  input  logic [tlb_pkg::PPN_W-1:0]  fill_ppn_i,
  input  logic                       fill_dir_i,
  input  logic                       fill_user_i,
  input  logic                       fill_write_i,
  input  logic                       fill_global_i,
  input  logic                       flush_all_i,
  input  logic                       flush_task_i,
  output logic                       rsp_valid_o,
  output logic                       rsp_hit_o,
  output logic                       rsp_dir_o,
  output logic [tlb_pkg::PPN_W-1:0]  rsp_ppn_o,
  output logic [tlb_pkg::PPN_W+tlb_pkg::OFF_W-1:0] rsp_pa_o,
  output logic                       rsp_user_o,
  output logic                       rsp_write_o,
  output logic                       rsp_global_o
);
  import tlb_pkg::*;
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = VPN_W - IDX_W;
  localparam int unsigned WW    = $clog2(WAYS);

  logic [SETS-1:0][WAYS-1:0]            valid_q, glb_q, dir_q, user_q, wr_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAYS-1:0][PPN_W-1:0] ppn_q;
  logic [SETS-1:0][WW-1:0]              ptr_q;

  // lookup request register
  logic             lu_v_q, lu_dir_q;
  logic [IDX_W-1:0] lu_idx_q;
  logic [TAG_W-1:0] lu_tag_q;
  logic [OFF_W-1:0] lu_off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lu_v_q   <= 1'b0;
      lu_dir_q <= 1'b0;
      lu_idx_q <= '0;
      lu_tag_q <= '0;
      lu_off_q <= '0;
    end else begin
      lu_v_q <= lu_valid_i;
      if (lu_valid_i) begin
        lu_dir_q <= lu_dir_i;
        lu_idx_q <= lu_vpn_i[IDX_W-1:0];
        lu_tag_q <= lu_vpn_i[VPN_W-1:IDX_W];
        lu_off_q <= lu_off_i;
      end
    end
  end

  // response: compares against state updated at the strobe edge
  logic [WAYS-1:0] lu_hit;
  tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lu_match (
    .valid_i (valid_q[lu_idx_q]),
    .dir_i   (dir_q[lu_idx_q]),
    .tag_i   (tag_q[lu_idx_q]),
    .tag_q_i (lu_tag_q),
    .dir_q_i (lu_dir_q),
    .hit_o   (lu_hit)
  );

  always_comb begin
    rsp_ppn_o    = '0;
    rsp_user_o   = 1'b0;
    rsp_write_o  = 1'b0;
    rsp_global_o = 1'b0;
    rsp_dir_o    = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (lu_v_q && lu_hit[w]) begin
        rsp_ppn_o    = rsp_ppn_o | ppn_q[lu_idx_q][w];
        rsp_user_o   = rsp_user_o | user_q[lu_idx_q][w];
        rsp_write_o  = rsp_write_o | wr_q[lu_idx_q][w];
        rsp_global_o = rsp_global_o | glb_q[lu_idx_q][w];
        rsp_dir_o    = rsp_dir_o | dir_q[lu_idx_q][w];
      end
    end
  end

  assign rsp_valid_o = lu_v_q;
  assign rsp_hit_o   = lu_v_q && (|lu_hit);
  assign rsp_pa_o    = rsp_hit_o ? {rsp_ppn_o, lu_off_q} : '0;

  // fill path
  logic             fill_en, f_rr;
  logic [IDX_W-1:0] f_idx;
  logic [TAG_W-1:0] f_tag;
  logic [WAYS-1:0]  f_match;
  logic [WW-1:0]    f_way;

  assign fill_en = fill_i && !flush_all_i && !flush_task_i;
  assign f_idx   = fill_vpn_i[IDX_W-1:0];
  assign f_tag   = fill_vpn_i[VPN_W-1:IDX_W];

  tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fill_match (
    .valid_i (valid_q[f_idx]),
    .dir_i   (dir_q[f_idx]),
    .tag_i   (tag_q[f_idx]),
    .tag_q_i (f_tag),
    .dir_q_i (fill_dir_i),
    .hit_o   (f_match)
  );

  tlb_victim #(.WAYS(WAYS)) u_victim (
    .valid_i (valid_q[f_idx]),
    .match_i (f_match),
    .ptr_i   (ptr_q[f_idx]),
    .way_o   (f_way),
    .rr_o    (f_rr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      glb_q   <= '0;
      dir_q   <= '0;
      user_q  <= '0;
      wr_q    <= '0;
      ptr_q   <= '0;
    end else if (flush_all_i) begin
      valid_q <= '0;
    end else if (flush_task_i) begin
      valid_q <= valid_q & glb_q;
    end else if (fill_en) begin
      valid_q[f_idx][f_way] <= 1'b1;
      glb_q[f_idx][f_way]   <= fill_global_i;
      dir_q[f_idx][f_way]   <= fill_dir_i;
      user_q[f_idx][f_way]  <= fill_user_i;
      wr_q[f_idx][f_way]    <= fill_write_i;
      if (f_rr) ptr_q[f_idx] <= ptr_q[f_idx] + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en) begin
      tag_q[f_idx][f_way] <= f_tag;
      ppn_q[f_idx][f_way] <= fill_ppn_i;
    end
  end

  // assertions
  assert_rsp_timing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o == $past(lu_valid_i));
  assert_single_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $onehot0(lu_hit));
  assert_flush_all_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (valid_q == '0));
  assert_flush_task_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_task_i && !flush_all_i) |=> (valid_q == $past(valid_q & glb_q)));
  assert_fill_grow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en && !(|f_match) && !(&valid_q[f_idx])) |=>
      ($countones(valid_q[$past(f_idx)]) == $countones($past(valid_q[f_idx])) + 1));
  assert_fill_reuse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en && (|f_match)) |=> $stable(ptr_q));
endmodule

// File: tb/tb_tlb_sa.sv
module tb_tlb_sa;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        lu_valid = 0, lu_dir = 0;
  logic [19:0] lu_vpn = 0;
  logic [11:0] lu_off = 0;
  logic        fill = 0, f_dir = 0, f_user = 0, f_write = 0, f_glb = 0;
  logic [19:0] f_vpn = 0, f_ppn = 0;
  logic        fl_all = 0, fl_task = 0;
  logic        rsp_valid, rsp_hit, rsp_dir, rsp_user, rsp_write, rsp_glb;
  logic [19:0] rsp_ppn;
  logic [31:0] rsp_pa;

  tlb_sa dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lu_valid_i(lu_valid), .lu_vpn_i(lu_vpn), .lu_off_i(lu_off), .lu_dir_i(lu_dir),
    .fill_i(fill), .fill_vpn_i(f_vpn), .fill_ppn_i(f_ppn), .fill_dir_i(f_dir),
    .fill_user_i(f_user), .fill_write_i(f_write), .fill_global_i(f_glb),
    .flush_all_i(fl_all), .flush_task_i(fl_task),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_dir_o(rsp_dir),
    .rsp_ppn_o(rsp_ppn), .rsp_pa_o(rsp_pa), .rsp_user_o(rsp_user),
    .rsp_write_o(rsp_write), .rsp_global_o(rsp_glb)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_fill(logic [19:0] vpn, logic [19:0] ppn, logic d, logic u, logic w, logic g);
    @(negedge clk);
    fill = 1; f_vpn = vpn; f_ppn = ppn; f_dir = d; f_user = u; f_write = w; f_glb = g;
    @(negedge clk);
    fill = 0;
  endtask

  // lookup; outputs sampled at the negedge after the capturing edge
  task automatic look(logic [19:0] vpn, logic [11:0] off, logic d);
    @(negedge clk);
    lu_valid = 1; lu_vpn = vpn; lu_off = off; lu_dir = d;
    @(negedge clk);
    lu_valid = 0;
  endtask

  task automatic expect_hit(string req, logic [19:0] vpn, logic d, logic [19:0] ppn);
    look(vpn, 12'h0, d);
    chk(req, rsp_hit, 1);
    chk(req, rsp_ppn, ppn);
  endtask

  task automatic expect_miss(string req, logic [19:0] vpn, logic d);
    look(vpn, 12'h0, d);
    chk(req, rsp_hit, 0);
  endtask

  task automatic t_reset;
    chk("R1 idle", rsp_valid, 0);
    look(20'h12345, 12'h678, 0);
    chk("R1 valid", rsp_valid, 1);
    chk("R3 miss", rsp_hit, 0);
    chk("R4 miss zero", rsp_pa, 0);
    @(negedge clk);
    chk("R1 one cycle", rsp_valid, 0);
  endtask

  task automatic t_page_hit;
    do_fill(20'h12345, 20'hABCDE, 0, 1, 0, 0);
    look(20'h12345, 12'h678, 0);
    chk("R4 hit", rsp_hit, 1);
    chk("R4 pa", rsp_pa, 32'hABCDE678);
    chk("R4 user", rsp_user, 1);
    chk("R4 write", rsp_write, 0);
    chk("R4 global", rsp_glb, 0);
    chk("R5 kind page", rsp_dir, 0);
  endtask

  task automatic t_kind;
    expect_miss("R5 dir miss", 20'h12345, 1);
    do_fill(20'h12345, 20'h00111, 1, 0, 1, 0);
    look(20'h12345, 12'h0, 1);
    chk("R5 dir hit", rsp_hit, 1);
    chk("R5 dir flag", rsp_dir, 1);
    chk("R5 dir ppn", rsp_ppn, 20'h00111);
    expect_hit("R5 page kept", 20'h12345, 0, 20'hABCDE);
  endtask

  task automatic t_index;
    expect_miss("R2 other set", 20'h12346, 0);
    expect_miss("R2 other tag", 20'h12355, 0);
  endtask

  function automatic logic [19:0] s3(int t);
    return 20'((t << 4) | 3);
  endfunction

  task automatic t_replace;
    for (int t = 1; t <= 4; t++) do_fill(s3(t), 20'(32'h100 + t), 0, 0, 0, 0);
    for (int t = 1; t <= 4; t++) expect_hit("R7 four resident", s3(t), 0, 20'(32'h100 + t));
    do_fill(s3(5), 20'h105, 0, 0, 0, 0);   // evicts way 0
    expect_miss("R8 evict way0", s3(1), 0);
    expect_hit("R8 new", s3(5), 0, 20'h105);
    expect_hit("R8 keep", s3(2), 0, 20'h102);
    do_fill(s3(6), 20'h106, 0, 0, 0, 0);   // evicts way 1
    expect_miss("R8 evict way1", s3(2), 0);
    expect_hit("R8 keep3", s3(3), 0, 20'h103);
    do_fill(s3(5), 20'h1FF, 0, 0, 0, 0);   // overwrite, pointer stays 2
    expect_hit("R6 overwrite", s3(5), 0, 20'h1FF);
    do_fill(s3(7), 20'h107, 0, 0, 0, 0);   // evicts way 2
    expect_miss("R6 ptr held", s3(3), 0);
    expect_hit("R6 way3 kept", s3(4), 0, 20'h104);
    expect_hit("R6 way1 kept", s3(6), 0, 20'h106);
  endtask

  task automatic t_task_flush;
    do_fill(20'h0AAA7, 20'h00777, 0, 0, 1, 1);
    do_fill(20'h0BBB7, 20'h00888, 0, 0, 1, 0);
    @(negedge clk); fl_task = 1;
    @(negedge clk); fl_task = 0;
    look(20'h0AAA7, 12'h0, 0);
    chk("R9 global kept", rsp_hit, 1);
    chk("R9 global bit", rsp_glb, 1);
    expect_miss("R9 local dropped", 20'h0BBB7, 0);
    expect_miss("R9 set5 dropped", 20'h12345, 0);
  endtask

  task automatic t_full_flush;
    @(negedge clk); fl_all = 1;
    @(negedge clk); fl_all = 0;
    expect_miss("R10 global dropped", 20'h0AAA7, 0);
    // pointer of set 3 is now 3; empty set refills by lowest invalid way
    for (int t = 8'h20; t <= 8'h23; t++) do_fill(s3(t), 20'(t), 0, 0, 0, 0);
    for (int t = 8'h20; t <= 8'h23; t++) expect_hit("R7 refill", s3(t), 0, 20'(t));
    do_fill(s3(8'h24), 20'h24, 0, 0, 0, 0);
    expect_miss("R8 ptr survives flush", s3(8'h23), 0);
    expect_hit("R8 way0 kept", s3(8'h20), 0, 20'h20);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    fill = 1; f_vpn = 20'h55552; f_ppn = 20'h0CAFE; f_dir = 0; f_user = 0; f_write = 1; f_glb = 0;
    lu_valid = 1; lu_vpn = 20'h55552; lu_off = 12'h0AB; lu_dir = 0;
    @(negedge clk);
    fill = 0; lu_valid = 0;
    chk("R12 hit", rsp_hit, 1);
    chk("R12 pa", rsp_pa, 32'h0CAFE0AB);
    @(negedge clk);
    fl_all = 1; fill = 1; f_vpn = 20'h66662; f_ppn = 20'h00666;
    @(negedge clk);
    fl_all = 0; fill = 0;
    expect_miss("R11 fill dropped", 20'h66662, 0);
    expect_miss("R11 flushed", 20'h55552, 0);
    @(negedge clk);
    fl_task = 1; fill = 1; f_vpn = 20'h77772; f_ppn = 20'h00777; f_glb = 1;
    @(negedge clk);
    fl_task = 0; fill = 0; f_glb = 0;
    expect_miss("R11 task fill dropped", 20'h77772, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_page_hit;
    t_kind;
    t_index;
    t_replace;
    t_task_flush;
    t_full_flush;
    t_same_cycle;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule